// File: doc/BRIEF.md
# Integer Execute Unit

A purely combinational execute stage for a compact 32-bit load-store integer instruction subset. An upstream decoder presents an operation select code, two register operands, a 5-bit shift field and a 16-bit immediate. The unit returns one 32-bit result in the same cycle. There are no registers inside the unit.

The unit covers add and subtract, four bitwise logic operations, constant-amount logical shifts and a signed set-if-less-than. On the immediate side it provides an add with a sign-extended constant, an OR with a zero-extended constant, and a load of the constant into the upper half. A load-upper followed by an OR-immediate therefore builds any 32-bit constant. An operation code outside the supported set gives a zero result and raises a flag, so the surrounding pipeline can raise an exception.

Top module: `int_exec_unit`

## Requirements
- R1: With `op_sel` = 0 (add), `result` equals `src_a + src_b` modulo 2^32.
- R2: With `op_sel` = 1 (subtract), `result` equals `src_a - src_b` modulo 2^32. The operand order is kept.
- R3: `op_sel` = 2, 3, 4 and 5 give the bitwise AND, OR, NOR and XOR of `src_a` and `src_b`.
- R4: With `op_sel` = 6, `result` is `src_b` shifted left by `shamt` bits, with the vacated low bits set to zero.
- R5: With `op_sel` = 7, `result` is `src_b` shifted right by `shamt` bits, with the vacated high bits set to zero.
- R6: With `op_sel` = 8, `result` is 1 when `src_a` is less than `src_b` as signed two's-complement values, and 0 otherwise.
- R7: With `op_sel` = 9, `result` equals `src_a` plus `imm` sign-extended to 32 bits. A negative constant therefore decrements.
- R8: With `op_sel` = 10, `result` holds `imm` in bits 31..16 and zero in bits 15..0.
- R9: With `op_sel` = 11, `result` equals `src_a` OR `imm` zero-extended. Bits 31..16 of `src_a` pass through unchanged.
- R10: For `op_sel` 12 to 15, `result` is zero and `illegal_op` is 1. For every code from 0 to 11, `illegal_op` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Decoded operation select |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| shamt | input | 5 | Constant shift amount |
| imm | input | 16 | Instruction immediate |
| result | output | 32 | Execute result |
| illegal_op | output | 1 | Unsupported operation select |

## Verification
The hardest situation to reach is a signed comparison whose operands straddle the sign boundary. In those cases the unsigned difference wraps, and a design that compares through the subtractor's sign bit gives the wrong answer. Random operands seldom land there. The stimulus therefore crosses every operation with a fixed set of extreme values: zero, one, all ones, the most positive and most negative numbers, and mixed patterns. It also sweeps all 32 shift amounts and a set of immediates with either sign bit before a random phase.

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input  logic [3:0]             op_sel,
  input  logic [XLEN-1:0]        src_a,
  input  logic [XLEN-1:0]        src_b,
  input  logic [$clog2(XLEN)-1:0] shamt,
  input  logic [IMMW-1:0]        imm,
  output logic [XLEN-1:0]        result,
  output logic                   illegal_op
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2,
                         OP_OR = 4'd3, OP_NOR = 4'd4, OP_XOR = 4'd5,
                         OP_SLL = 4'd6, OP_SRL = 4'd7, OP_SLT = 4'd8,
                         OP_ADDI = 4'd9, OP_LUI = 4'd10, OP_ORI = 4'd11;

  wire [XLEN-1:0] imm_sx = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  wire [XLEN-1:0] imm_zx = {{(XLEN-IMMW){1'b0}}, imm};
  wire [XLEN-1:0] imm_hi = {imm, {(XLEN-IMMW){1'b0}}};
  wire            a_lt_b = (src_a[XLEN-1] != src_b[XLEN-1]) ? src_a[XLEN-1]
                                                            : (src_a < src_b);

  always_comb begin
    illegal_op = 1'b0;
    case (op_sel)
      OP_ADD:  result = src_a + src_b;
      OP_SUB:  result = src_a - src_b;
      OP_AND:  result = src_a & src_b;
      OP_OR:   result = src_a | src_b;
      OP_NOR:  result = ~(src_a | src_b);
      OP_XOR:  result = src_a ^ src_b;
      OP_SLL:  result = src_b << shamt;
      OP_SRL:  result = src_b >> shamt;
      OP_SLT:  result = {{(XLEN-1){1'b0}}, a_lt_b};
      OP_ADDI: result = src_a + imm_sx;
      OP_LUI:  result = imm_hi;
      OP_ORI:  result = src_a | imm_zx;
      default: begin
        result     = '0;
        illegal_op = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input logic [3:0]              op_sel,
  input logic [XLEN-1:0]         src_a,
  input logic [XLEN-1:0]         src_b,
  input logic [$clog2(XLEN)-1:0] shamt,
  input logic [IMMW-1:0]         imm,
  input logic [XLEN-1:0]         result,
  input logic                    illegal_op
);
  always_comb begin
    if (illegal_op) assert_illegal_zero_R10: assert (result == '0);
    if (op_sel < 4'd12) assert_legal_noflag_R10: assert (!illegal_op);
    if (op_sel == 4'd1 && src_b == '0) assert_sub_zero_R2: assert (result == src_a);
    if (op_sel == 4'd6 && shamt == '0) assert_sll_zero_R4: assert (result == src_b);
    if (op_sel == 4'd7 && shamt == '0) assert_srl_zero_R5: assert (result == src_b);
    if (op_sel == 4'd8) assert_slt_bool_R6: assert (result[XLEN-1:1] == '0);
    if (op_sel == 4'd9 && imm == '0) assert_addi_zero_R7: assert (result == src_a);
    if (op_sel == 4'd10) assert_lui_low_R8: assert (result[XLEN-IMMW-1:0] == '0 && result[XLEN-1:XLEN-IMMW] == imm);
    if (op_sel == 4'd11) assert_ori_upper_R9: assert (result[XLEN-1:IMMW] == src_a[XLEN-1:IMMW]);
    if (op_sel == 4'd2 && src_a == src_b) assert_and_same_R3: assert (result == src_a);
  end
endmodule

bind int_exec_unit int_exec_unit_chk #(.XLEN(XLEN), .IMMW(IMMW)) u_chk (.*);

// File: tb/sim_int_exec_unit.sv
`timescale 1ns/1ps
module sim_int_exec_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]  op_sel = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [4:0]  shamt = '0;
  logic [15:0] imm = '0;
  logic [31:0] result;
  logic        illegal_op;

  int_exec_unit u0 (.op_sel(op_sel), .src_a(src_a), .src_b(src_b), .shamt(shamt),
                    .imm(imm), .result(result), .illegal_op(illegal_op));

  int n_chk = 0, n_fail = 0;
  logic [31:0] pats [8];

  function automatic string tag_of(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2, 3, 4, 5: return "R3";
      6: return "R4";
      7: return "R5";
      8: return "R6";
      9: return "R7";
      10: return "R8";
      11: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] model(input int op, input logic [31:0] a, b,
                                        input int s, input logic [15:0] k);
    longint sa, sb, kx;
    sa = a[31] ? longint'(a) - 64'h1_0000_0000 : longint'(a);
    sb = b[31] ? longint'(b) - 64'h1_0000_0000 : longint'(b);
    kx = k[15] ? longint'(k) - 65536 : longint'(k);
    case (op)
      0: return 32'(longint'(a) + longint'(b));
      1: return 32'(longint'(a) - longint'(b) + 64'h1_0000_0000);
      2: return a & b;
      3: return a | b;
      4: return ~(a | b);
      5: return a ^ b;
      6: return 32'(longint'(b) * (64'd1 << s));
      7: return 32'(longint'(b) / (64'd1 << s));
      8: return (sa < sb) ? 32'd1 : 32'd0;
      9: return 32'(longint'(a) + kx + 64'h1_0000_0000);
      10: return 32'(longint'(k) * 65536);
      11: return a | {16'h0, k};
      default: return 32'd0;
    endcase
  endfunction

  task automatic apply(input int op, input logic [31:0] a, b, input int s,
                       input logic [15:0] k);
    logic [31:0] exp_r;
    logic exp_bad;
    @(posedge clk);
    op_sel = 4'(op); src_a = a; src_b = b; shamt = 5'(s); imm = k;
    exp_r = model(op, a, b, s, k);
    exp_bad = (op >= 12);
    @(negedge clk);
    n_chk++;
    if (result !== exp_r || illegal_op !== exp_bad) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h s=%0d imm=%h: result=%h flag=%b expected %h flag=%b",
               tag_of(op), op, a, b, s, k, result, illegal_op, exp_r, exp_bad);
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    pats[0] = 32'h0000_0000; pats[1] = 32'h0000_0001; pats[2] = 32'hFFFF_FFFF;
    pats[3] = 32'h7FFF_FFFF; pats[4] = 32'h8000_0000; pats[5] = 32'h1234_5678;
    pats[6] = 32'hFFFE_0001; pats[7] = 32'h0001_0000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset-like idle state: add of zeros, no flag (R1, R10)
    apply(0, 32'h0, 32'h0, 0, 16'h0);
    // register-register ops over the corner cross product (R1 R2 R3 R6 R10)
    for (int op = 0; op < 16; op++)
      if (op != 6 && op != 7 && op < 9 || op >= 12)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            apply(op, pats[i], pats[j], 0, 16'h0);
    // every shift amount on each pattern (R4, R5)
    for (int op = 6; op < 8; op++)
      for (int s = 0; s < 32; s++)
        for (int j = 0; j < 8; j++)
          apply(op, pats[(j + 3) % 8], pats[j], s, 16'h0);
    // immediate ops with both immediate signs (R7 R8 R9)
    for (int op = 9; op < 12; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          apply(op, pats[i], 32'h0, 0, pats[j][15:0] ^ pats[(j + 5) % 8][31:16]);
    // decrement through negative immediate (R7)
    apply(9, 32'd10, 32'h0, 0, 16'hFFFF);
    // full constant built by upper load then or-immediate (R8, R9)
    apply(10, 32'h0, 32'h0, 0, 16'hDEAD);
    apply(11, 32'hDEAD_0000, 32'h0, 0, 16'hBEEF);
    // random phase across every code
    lf = 32'hACE1_2345;
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ra, rb;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      ra = lf * 32'h9E37_79B9;
      rb = (lf ^ 32'h5A5A_A5A5) * 32'h85EB_CA6B;
      apply(n % 16, ra, rb, int'(lf[4:0]), lf[20:5]);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule